// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers single-cycle cause pulses from device-side sources into a 32-bit status register. The host sees that register alongside an enable mask and drives one interrupt line from them. The host acknowledges a cause by writing a one to its bit. To limit interrupt rate, the line is held back by a programmable coalescing delay. The delay is counted in units of 32 microseconds, and an internal prescaler derives the microsecond tick from the clock.

A high-priority receive pulse sets the receive-DMA cause and raises the line at once, bypassing the delay. A separate periodic timer byte can post a periodic-receive cause at a fixed interval. The host reaches all four registers through a plain word-indexed read/write port. Writes complete in one cycle and reads return data combinationally.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, the registers read as follows: status (address 0) reads 0, mask (address 1) reads 0, coalescing delay (address 2) reads 0x40, period (address 3) reads 0, and `host_irq_o` is low.
- R2: A pulse on `cause_pulse_i[i]` sets status bit i on the next clock edge when i is an implemented cause: 31 receive DMA, 29 hardware error, 28 periodic receive, 27 transmit DMA, 26 scheduler, 25 software error, 7 RF off, 6 over-temperature, 3 software receive, 1 wakeup, 0 alive. The other status bits always read 0.
- R3: Writing to status clears each bit whose written value is 1. Bits written with 0 are left unchanged.
- R4: When a cause pulse and a write-1-to-clear hit the same bit in the same cycle, the bit stays set.
- R5: `host_irq_o` is only ever high while (status AND mask) is nonzero. A cause whose mask bit is 0 never raises it.
- R6: Suppose the delay register holds D, with D nonzero, and the controller is idle. A masked status bit that becomes set at clock edge E starts the timer. `host_irq_o` then rises at edge E + D·32·CYC_PER_US. The delay register keeps only the low 8 bits of a write.
- R7: With a delay of 0, `host_irq_o` rises on the same edge that sets the masked status bit, which is the cycle after the cause pulse.
- R8: A pulse on `hipri_rx_i` sets status bit 31. If mask bit 31 is set, `host_irq_o` rises on that same edge, whether the controller is idle or already timing a delay.
- R9: Writing a nonzero value P to the period register (address 3) sets status bit 28 every P·32·CYC_PER_US cycles, counted from the edge of the write. Writing 0 stops it. The register keeps 8 bits.
- R10: `host_irq_o` falls on the edge at which the host clears the last pending masked status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_pulse_i | input | 32 | One-cycle cause pulses, one per status bit |
| hipri_rx_i | input | 1 | High-priority receive pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The bench aims at the exact edge on which the line rises after a delay, for both a short delay and the reset default. A controller that counted one unit too many or too few, or that used a free-running prescaler, would miss that edge. It also aims at a cause colliding with a clear in the same cycle: a controller that let the clear win would drop an event. A high-priority pulse that arrives while a delay is in progress must raise the line at once. Getting this wrong would leave the line low until the timer runs out. The bench also checks that a masked-off cause and an unimplemented bit leave the line and the status register unchanged, and that the periodic timer is silent after it is disabled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW = 32;
  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_MASK   = 2'd1;
  localparam logic [1:0] A_DELAY  = 2'd2;
  localparam logic [1:0] A_PERIOD = 2'd3;

  localparam int C_BOOT  = 0;
  localparam int C_WAKE  = 1;
  localparam int C_SWRX  = 3;
  localparam int C_HOT   = 6;
  localparam int C_RFOFF = 7;
  localparam int C_SWERR = 25;
  localparam int C_SCHED = 26;
  localparam int C_TXDMA = 27;
  localparam int C_RXPER = 28;
  localparam int C_HWERR = 29;
  localparam int C_RXDMA = 31;

  localparam logic [DW-1:0] IMPL_MASK =
    (DW'(1) << C_BOOT)  | (DW'(1) << C_WAKE)  | (DW'(1) << C_SWRX)  |
    (DW'(1) << C_HOT)   | (DW'(1) << C_RFOFF) | (DW'(1) << C_SWERR) |
    (DW'(1) << C_SCHED) | (DW'(1) << C_TXDMA) | (DW'(1) << C_RXPER) |
    (DW'(1) << C_HWERR) | (DW'(1) << C_RXDMA);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_FIRE = 2'd2} coal_st_e;
endpackage

// File: rtl/irqc_unit_tick.sv
module irqc_unit_tick #(
  parameter int CYC_PER_US = 2,
  parameter int UNIT_US    = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic unit_tick_o
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int UW = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(CYC_PER_US - 1);
  localparam logic [UW-1:0] US_MAX  = UW'(UNIT_US - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [UW-1:0] us_q, us_d;
  logic          us_tick;

  assign us_tick     = run_i && (pre_q == PRE_MAX);
  assign unit_tick_o = us_tick && (us_q == US_MAX);

  always_comb begin
    pre_d = pre_q;
    us_d  = us_q;
    if (restart_i) begin
      pre_d = '0;
      us_d  = '0;
    end else if (us_tick) begin
      pre_d = '0;
      us_d  = (us_q == US_MAX) ? '0 : us_q + 1'b1;
    end else if (run_i) begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] stat_nxt_o
);
  logic [DW-1:0] stat_q;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      assign stat_nxt_o[i] = set_i[i] | (stat_q[i] & ~clr_i[i]);
    end else begin : g_none
      assign stat_nxt_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt_o;
  end

  assign stat_o = stat_q;

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(set_i)) == ($past(set_i) & IMPL_MASK)));
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/irqc_coalesce.sv
module irqc_coalesce
  import irqc_pkg::*;
#(
  parameter int CYC_PER_US = 2,
  parameter int UNIT_US    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_i,
  input  logic       pend_nxt_i,
  input  logic       hipri_i,
  input  logic [7:0] dly_i,
  output logic       irq_o
);
  coal_st_e   st_q, st_d;
  logic [7:0] rem_q, rem_d;
  logic       tick;

  irqc_unit_tick #(.CYC_PER_US(CYC_PER_US), .UNIT_US(UNIT_US)) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (st_q != ST_WAIT),
    .run_i       (st_q == ST_WAIT),
    .unit_tick_o (tick)
  );

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    unique case (st_q)
      ST_IDLE: begin
        rem_d = dly_i;
        if (pend_nxt_i) st_d = (dly_i == 8'd0 || hipri_i) ? ST_FIRE : ST_WAIT;
      end
      ST_WAIT: begin
        if (!pend_nxt_i)                            st_d = ST_IDLE;
        else if (hipri_i || (tick && rem_q == 8'd1)) st_d = ST_FIRE;
        else if (tick)                               rem_d = rem_q - 8'd1;
      end
      ST_FIRE: if (!pend_nxt_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end

  assign irq_o = (st_q == ST_FIRE);

  // R5
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_i);
  // R7
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && pend_nxt_i && dly_i == 8'd0) |=> irq_o);
  // R8
  hipri_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hipri_i && pend_nxt_i) |=> irq_o);
  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !tick && !hipri_i) |=> !irq_o);
endmodule

// File: rtl/irqc_periodic.sv
module irqc_periodic #(
  parameter int CYC_PER_US = 2,
  parameter int UNIT_US    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic [7:0] per_i,
  output logic       evt_o
);
  logic [7:0] cnt_q, cnt_d;
  logic       tick, on, hit;

  assign on = (per_i != 8'd0);

  irqc_unit_tick #(.CYC_PER_US(CYC_PER_US), .UNIT_US(UNIT_US)) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (restart_i || !on),
    .run_i       (on),
    .unit_tick_o (tick)
  );

  assign hit   = tick && (cnt_q == per_i - 8'd1);
  assign evt_o = on && hit && !restart_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || !on) cnt_d = '0;
    else if (hit)         cnt_d = '0;
    else if (tick)        cnt_d = cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_i == 8'd0) |-> !evt_o);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import irqc_pkg::*;
#(
  parameter int         CYC_PER_US = 2,
  parameter int         UNIT_US    = 32,
  parameter logic [7:0] DLY_RST    = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cause_pulse_i,
  input  logic          hipri_rx_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          host_irq_o
);
  logic [DW-1:0] mask_q, mask_d;
  logic [7:0]    dly_q, dly_d, per_q, per_d;
  logic [DW-1:0] set_vec, clr_vec, stat, stat_nxt;
  logic          per_evt, per_wr, hipri_m;

  assign per_wr  = reg_wr_i && (reg_addr_i == A_PERIOD);
  assign clr_vec = (reg_wr_i && reg_addr_i == A_STATUS) ? reg_wdata_i : '0;

  always_comb begin
    set_vec          = cause_pulse_i;
    set_vec[C_RXDMA] = cause_pulse_i[C_RXDMA] | hipri_rx_i;
    set_vec[C_RXPER] = cause_pulse_i[C_RXPER] | per_evt;
  end

  always_comb begin
    mask_d = mask_q;
    dly_d  = dly_q;
    per_d  = per_q;
    if (reg_wr_i) begin
      unique case (reg_addr_i)
        A_MASK:   mask_d = reg_wdata_i;
        A_DELAY:  dly_d  = reg_wdata_i[7:0];
        A_PERIOD: per_d  = reg_wdata_i[7:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dly_q  <= DLY_RST;
      per_q  <= '0;
    end else begin
      mask_q <= mask_d;
      dly_q  <= dly_d;
      per_q  <= per_d;
    end
  end

  irqc_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .stat_o     (stat),
    .stat_nxt_o (stat_nxt)
  );

  irqc_periodic #(.CYC_PER_US(CYC_PER_US), .UNIT_US(UNIT_US)) u_periodic (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (per_wr),
    .per_i     (per_q),
    .evt_o     (per_evt)
  );

  assign hipri_m = hipri_rx_i && mask_d[C_RXDMA];

  irqc_coalesce #(.CYC_PER_US(CYC_PER_US), .UNIT_US(UNIT_US)) u_coalesce (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (|(stat & mask_q)),
    .pend_nxt_i (|(stat_nxt & mask_d)),
    .hipri_i    (hipri_m),
    .dly_i      (dly_q),
    .irq_o      (host_irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_STATUS: reg_rdata_o = stat;
      A_MASK:   reg_rdata_o = mask_q;
      A_DELAY:  reg_rdata_o = {24'd0, dly_q};
      default:  reg_rdata_o = {24'd0, per_q};
    endcase
  end
endmodule

// File: tb/irq_coalesce_ctrl_bench.sv
module irq_coalesce_ctrl_bench;
  localparam int CPU  = 2;
  localparam int UNIT = 32 * CPU;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cause;
  logic        hipri;
  logic        wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_coalesce_ctrl #(.CYC_PER_US(CPU)) u_irq_coalesce_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cause_pulse_i (cause),
    .hipri_rx_i    (hipri),
    .reg_wr_i      (wr),
    .reg_addr_i    (addr),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .host_irq_o    (irq)
  );

  // {wr, clear data, cause pulses, expected status}
  localparam logic [96:0] VEC [0:9] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001},  // R2 alive
    {1'b0, 32'h0000_0000, 32'h8000_0000, 32'h8000_0001},  // R2 receive DMA
    {1'b1, 32'h0000_0001, 32'h0000_0000, 32'h8000_0000},  // R3 clear one bit
    {1'b1, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000},  // R3 write zero
    {1'b1, 32'h0400_0000, 32'h0400_0000, 32'h8400_0000},  // R4 collision
    {1'b0, 32'h0000_0000, 32'h0000_0100, 32'h8400_0000},  // R2 unimplemented
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},  // R3 clear all
    {1'b0, 32'h0000_0000, 32'h3E00_00CB, 32'h3E00_00CB},  // R2 mixed causes
    {1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hBE00_00CB},  // R2 all pulses
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}   // R3 clear all
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] c, input logic h);
    @(negedge clk);
    cause = c; hipri = h;
    @(negedge clk);
    cause = '0; hipri = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cause = '0; hipri = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 status", v, 32'h0);
    rd(2'd1, v); chk("R1 mask", v, 32'h0);
    rd(2'd2, v); chk("R1 delay", v, 32'h40);
    rd(2'd3, v); chk("R1 period", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cause = VEC[i][63:32];
      if (VEC[i][96]) begin wr = 1'b1; addr = 2'd0; wdata = VEC[i][95:64]; end
      @(negedge clk);
      cause = '0; wr = 1'b0;
      rd(2'd0, v); chk("R2/R3/R4 vector", v, VEC[i][31:0]);
      chk("R5 masked-off irq", {31'd0, irq}, 32'd0);
    end

    // R6 default delay 0x40
    wreg(2'd1, 32'h0000_0001);
    pulse(32'h1, 1'b0);
    repeat (64 * UNIT - 1) @(negedge clk);
    chk("R6 default delay early", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R6 default delay rise", {31'd0, irq}, 32'd1);
    wreg(2'd0, 32'h1);
    chk("R10 irq drops on clear", {31'd0, irq}, 32'd0);

    // R6 8-bit delay register, short delay
    wreg(2'd2, 32'h1FF);
    rd(2'd2, v); chk("R6 delay width", v, 32'hFF);
    wreg(2'd2, 32'd2);
    pulse(32'h1, 1'b0);
    repeat (2 * UNIT - 1) @(negedge clk);
    chk("R6 delay 2 early", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R6 delay 2 rise", {31'd0, irq}, 32'd1);
    wreg(2'd0, 32'h1);

    // R7 zero delay
    wreg(2'd2, 32'd0);
    pulse(32'h1, 1'b0);
    chk("R7 zero delay", {31'd0, irq}, 32'd1);
    wreg(2'd0, 32'hFFFF_FFFF);
    chk("R10 cleared", {31'd0, irq}, 32'd0);

    // R5 unmasked cause with no delay stays quiet
    pulse(32'h2, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5 masked cause irq", {31'd0, irq}, 32'd0);
    rd(2'd0, v); chk("R5 masked cause status", v, 32'h2);
    wreg(2'd0, 32'h2);

    // R8 high priority bypass, from idle and during a wait
    wreg(2'd2, 32'd3);
    wreg(2'd1, 32'h8000_0001);
    pulse(32'h0, 1'b1);
    chk("R8 hipri idle", {31'd0, irq}, 32'd1);
    rd(2'd0, v); chk("R8 hipri status", v, 32'h8000_0000);
    wreg(2'd0, 32'h8000_0000);
    pulse(32'h1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R6 waiting", {31'd0, irq}, 32'd0);
    pulse(32'h0, 1'b1);
    chk("R8 hipri during wait", {31'd0, irq}, 32'd1);
    wreg(2'd0, 32'hFFFF_FFFF);

    // R9 periodic cause
    wreg(2'd2, 32'd0);
    wreg(2'd1, 32'h1000_0000);
    wreg(2'd3, 32'd2);
    repeat (2 * UNIT - 1) @(negedge clk);
    chk("R9 periodic early", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R9 periodic rise", {31'd0, irq}, 32'd1);
    rd(2'd0, v); chk("R9 periodic status", v, 32'h1000_0000);
    wreg(2'd3, 32'd0);
    wreg(2'd0, 32'hFFFF_FFFF);
    repeat (5 * UNIT) @(negedge clk);
    chk("R9 disabled irq", {31'd0, irq}, 32'd0);
    rd(2'd0, v); chk("R9 disabled status", v, 32'h0);

    finish_run();
  end
endmodule